// File: doc/BRIEF.md
# Fast-Lock Timer and Charge-Pump Current Select

This block decides which of two 3-bit charge-pump current codes reaches the charge pump: the normal code or the fast code. It also drives the loop-filter bypass switch and the charge-pump high-impedance enable. It holds the gain-select bit that arrives with each write of the N-divider register. The analog side scales the pump current as the minimum current times (code + 1). The block only produces the code.

When the mode field is `2'b11`, the gain bit stops being a plain selector and becomes a trigger. An N-register write that carries gain = 1 starts a timer that advances on the phase-detector rate tick. While the timer runs, the fast code is selected and the bypass switch is closed. After 3 + 4×`tmr_code` ticks the block clears its own gain bit, opens the switch and returns to the normal code. For any other mode value the gain bit selects the code directly.

An initialization write parks the charge pump in high impedance and stops the timer. The next N-register write wakes the pump again. A separate tri-state request forces high impedance at any time. All pins are plain level or strobe controls. There is no streaming data, so there is no valid/ready handshake.

Top module: `flk_top`

## Requirements
- R1: After reset, `cp_hiz` is 1, `gain_out` is 0 and `filt_sw_on` is 0.
- R2: When `fast_mode` is not `2'b11`, a write (`nreg_wr`) stores `gain_in`. `cp_code` then equals `cur_fast` if the stored gain is 1 and `cur_norm` if it is 0. `filt_sw_on` stays 0.
- R3: With `fast_mode` = `2'b11`, a write carrying `gain_in` = 1 starts the timed period. From the next cycle `cp_code` = `cur_fast`, `filt_sw_on` = 1 and `gain_out` = 1.
- R4: The timed period lasts exactly 3 + 4×`tmr_code` `pfd_tick` pulses, with `tmr_code` sampled at the start. In the cycle after the last pulse, `cp_code` = `cur_norm` and `filt_sw_on` = 0.
- R5: At timeout `gain_out` returns to 0. Further ticks without a new write do not restart the timer.
- R6: A qualifying write while the timer runs restarts the count from zero.
- R7: Ticks that arrive while `pwr_down` = 1 are not counted. The period resumes where it stopped.
- R8: `init_wr` stops the timer and sets `cp_hiz` from the next cycle. A following `nreg_wr` clears `cp_hiz`. If both strobes arrive in the same cycle, `init_wr` wins and the write is dropped.
- R9: `tristate_req` = 1 forces `cp_hiz` = 1 without disturbing the timer.
- R10: If `fast_mode` leaves `2'b11` during the timed period, the timer is abandoned and `filt_sw_on` drops. `gain_out` stays 1 and then acts as a static selector.
- R11: With `fast_mode` = `2'b11`, a write carrying `gain_in` = 0 selects `cur_norm` with the switch open, and it stops a running timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pfd_tick | input | 1 | One-cycle pulse at the phase-detector rate |
| pwr_down | input | 1 | Synthesizer power-down; freezes the timer |
| fast_mode | input | 2 | Mode field; `2'b11` arms timed fast lock |
| gain_in | input | 1 | Gain bit carried by the N-register write |
| tmr_code | input | 4 | Period code; period = 3 + 4×code ticks |
| cur_norm | input | 3 | Normal current code |
| cur_fast | input | 3 | Fast current code |
| nreg_wr | input | 1 | N-register write strobe |
| init_wr | input | 1 | Initialization write strobe |
| tristate_req | input | 1 | Forces the charge pump to high impedance |
| cp_code | output | 3 | Selected current code |
| filt_sw_on | output | 1 | Loop-filter bypass switch enable |
| cp_hiz | output | 1 | Charge-pump high-impedance enable |
| gain_out | output | 1 | Current value of the gain bit |

## Verification
A counter that is off by one shows as `filt_sw_on` and `cp_code` switching back one tick early or late. The bench therefore probes the tick just before the end of the period and the tick that ends it, for the smallest, a middle and the largest period. A stuck park flag or a gain bit that never clears shows at `cp_hiz` or `gain_out` in the first cycle after the strobe that should change it. A timer that counts during power-down ends the period early by exactly the number of ticks that were missed.

// File: rtl/flk_pkg.sv
package flk_pkg;
  localparam logic [1:0] FAST_ARMED = 2'b11;
  localparam int unsigned PERIOD_BASE = 3;
  localparam int unsigned PERIOD_SHIFT = 2;
endpackage

// File: rtl/flk_timer.sv
module flk_timer #(
  parameter int unsigned TMR_W = 4,
  parameter int unsigned BASE  = 3,
  parameter int unsigned SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             tick_en,
  input  logic [TMR_W-1:0] tmr_code,
  output logic             active,
  output logic             expire
);
  localparam int unsigned CNT_W = TMR_W + SHIFT + 1;

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;
  logic             last;

  // period length is fixed at the start of each run
  assign lim_d  = CNT_W'(BASE) + (CNT_W'(tmr_code) << SHIFT);
  assign last   = (count_q + CNT_W'(1)) >= lim_q;
  assign expire = active && tick_en && last && !start && !stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      count_q <= '0;
      lim_q   <= CNT_W'(BASE);
    end else if (stop) begin
      active  <= 1'b0;
      count_q <= '0;
    end else if (start) begin
      active  <= 1'b1;
      count_q <= '0;
      lim_q   <= lim_d;
    end else if (active && tick_en) begin
      if (last) begin
        active  <= 1'b0;
        count_q <= '0;
      end else begin
        count_q <= count_q + CNT_W'(1);
      end
    end
  end

  // R4: the count never reaches the latched limit
  a_r4_count_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (count_q < lim_q));

  // R6: a start always begins from zero
  a_r6_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> (active && count_q == '0));

  // R7: with no tick enable the running count is frozen
  a_r7_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick_en && !start && !stop) |=> (active && $stable(count_q)));
endmodule

// File: rtl/flk_gain.sv
module flk_gain (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic gain_in,
  input  logic expire,
  input  logic init_wr,
  output logic gain_q,
  output logic parked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= 1'b0;
    end else if (wr) begin
      gain_q <= gain_in;
    end else if (expire) begin
      gain_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parked <= 1'b1;
    end else if (init_wr) begin
      parked <= 1'b1;
    end else if (wr) begin
      parked <= 1'b0;
    end
  end

  // R8: an initialization strobe parks the pump
  a_r8_init_parks: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> parked);

  // R5: an expiry with no competing write clears the gain bit
  a_r5_expire_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !wr) |=> !gain_q);
endmodule

// File: rtl/flk_sel.sv
module flk_sel #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              armed,
  input  logic              active,
  input  logic              gain_q,
  input  logic              parked,
  input  logic              tristate_req,
  input  logic [CODE_W-1:0] cur_norm,
  input  logic [CODE_W-1:0] cur_fast,
  output logic [CODE_W-1:0] cp_code,
  output logic              filt_sw_on,
  output logic              cp_hiz
);
  logic use_fast;

  always_comb begin
    if (armed) use_fast = active;
    else       use_fast = gain_q;
  end

  assign cp_code    = use_fast ? cur_fast : cur_norm;
  assign filt_sw_on = armed && active;
  assign cp_hiz     = parked || tristate_req;
endmodule

// File: rtl/flk_top.sv
module flk_top #(
  parameter int unsigned CODE_W = 3,
  parameter int unsigned TMR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfd_tick,
  input  logic              pwr_down,
  input  logic [1:0]        fast_mode,
  input  logic              gain_in,
  input  logic [TMR_W-1:0]  tmr_code,
  input  logic [CODE_W-1:0] cur_norm,
  input  logic [CODE_W-1:0] cur_fast,
  input  logic              nreg_wr,
  input  logic              init_wr,
  input  logic              tristate_req,
  output logic [CODE_W-1:0] cp_code,
  output logic              filt_sw_on,
  output logic              cp_hiz,
  output logic              gain_out
);
  import flk_pkg::*;

  logic armed, wr_eff, start, stop, tick_en;
  logic active, expire, gain_q, parked;

  assign armed   = (fast_mode == FAST_ARMED);
  assign wr_eff  = nreg_wr && !init_wr;
  assign start   = wr_eff && gain_in && armed;
  assign stop    = init_wr || (active && !armed) || (wr_eff && !(gain_in && armed));
  assign tick_en = pfd_tick && !pwr_down;

  flk_timer #(.TMR_W(TMR_W), .BASE(PERIOD_BASE), .SHIFT(PERIOD_SHIFT)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .tick_en(tick_en),
    .tmr_code(tmr_code), .active(active), .expire(expire)
  );

  flk_gain u_gain (
    .clk(clk), .rst_n(rst_n), .wr(wr_eff), .gain_in(gain_in), .expire(expire),
    .init_wr(init_wr), .gain_q(gain_q), .parked(parked)
  );

  flk_sel #(.CODE_W(CODE_W)) u_sel (
    .armed(armed), .active(active), .gain_q(gain_q), .parked(parked),
    .tristate_req(tristate_req), .cur_norm(cur_norm), .cur_fast(cur_fast),
    .cp_code(cp_code), .filt_sw_on(filt_sw_on), .cp_hiz(cp_hiz)
  );

  assign gain_out = gain_q;

  // R3: a closed bypass switch implies the gain bit is still set
  a_r3_switch_needs_gain: assert property (@(posedge clk) disable iff (!rst_n)
    filt_sw_on |-> gain_out);

  // R5: the timed period ends with the gain bit cleared, unless it was abandoned
  a_r5_end_drops_gain: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(active) && $past(armed) && !$past(init_wr)) |-> !gain_out);

  // R9: the tri-state request always reaches the pump
  a_r9_tristate_forces: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tristate_req) && $past(!parked)) |-> cp_hiz);
endmodule

// File: tb/flk_top_tb_top.sv
module flk_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_tick = 1'b0, pwr_down = 1'b0, gain_in = 1'b0;
  logic nreg_wr = 1'b0, init_wr = 1'b0, tristate_req = 1'b0;
  logic [1:0] fast_mode = 2'b00;
  logic [3:0] tmr_code = 4'd0;
  logic [2:0] cur_norm = 3'd1, cur_fast = 3'd6;
  logic [2:0] cp_code;
  logic filt_sw_on, cp_hiz, gain_out;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  flk_top dut_i (
    .clk(clk), .rst_n(rst_n), .pfd_tick(pfd_tick), .pwr_down(pwr_down),
    .fast_mode(fast_mode), .gain_in(gain_in), .tmr_code(tmr_code),
    .cur_norm(cur_norm), .cur_fast(cur_fast), .nreg_wr(nreg_wr),
    .init_wr(init_wr), .tristate_req(tristate_req), .cp_code(cp_code),
    .filt_sw_on(filt_sw_on), .cp_hiz(cp_hiz), .gain_out(gain_out)
  );

  // fast, gain, norm, fast code, expected code
  localparam logic [11:0] VEC [8] = '{
    {2'b00, 1'b0, 3'd2, 3'd5, 3'd2},
    {2'b00, 1'b1, 3'd2, 3'd5, 3'd5},
    {2'b01, 1'b1, 3'd0, 3'd7, 3'd7},
    {2'b01, 1'b0, 3'd0, 3'd7, 3'd0},
    {2'b10, 1'b1, 3'd3, 3'd4, 3'd4},
    {2'b10, 1'b0, 3'd6, 3'd1, 3'd6},
    {2'b11, 1'b0, 3'd4, 3'd7, 3'd4},
    {2'b00, 1'b1, 3'd7, 3'd0, 3'd0}
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr_n(input logic g);
    gain_in = g; nreg_wr = 1'b1;
    cyc();
    nreg_wr = 1'b0;
    cyc();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      pfd_tick = 1'b1;
      cyc();
      pfd_tick = 1'b0;
    end
    cyc();
  endtask

  task automatic fast_state(input logic on, input string tag);
    chk({7'd0, filt_sw_on}, {7'd0, on}, tag);
    chk({5'd0, cp_code}, {5'd0, (on ? cur_fast : cur_norm)}, tag);
    chk({7'd0, gain_out}, {7'd0, on}, tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    // R1 reset state
    chk({7'd0, cp_hiz}, 8'd1, "R1 hiz");
    chk({7'd0, gain_out}, 8'd0, "R1 gain");
    chk({7'd0, filt_sw_on}, 8'd0, "R1 sw");
    rst_n = 1'b1;
    cyc();

    // R2 / R11 static selection table
    for (int v = 0; v < 8; v++) begin
      fast_mode = VEC[v][11:10];
      cur_norm  = VEC[v][8:6];
      cur_fast  = VEC[v][5:3];
      wr_n(VEC[v][9]);
      chk({5'd0, cp_code}, {5'd0, VEC[v][2:0]}, "R2 R11 table code");
      chk({7'd0, filt_sw_on}, 8'd0, "R2 R11 table sw");
      chk({7'd0, cp_hiz}, 8'd0, "R2 table hiz");
    end

    cur_norm = 3'd1; cur_fast = 3'd6; fast_mode = 2'b11;
    // R3/R4/R5 smallest period: 3 ticks
    tmr_code = 4'd0;
    wr_n(1'b1);
    fast_state(1'b1, "R3 start");
    ticks(2);
    fast_state(1'b1, "R4 t0 before end");
    ticks(1);
    fast_state(1'b0, "R4 R5 t0 end");
    ticks(5);
    fast_state(1'b0, "R5 no self restart");

    // R4 middle and largest period
    tmr_code = 4'd2;
    wr_n(1'b1);
    tmr_code = 4'd0;
    ticks(10);
    fast_state(1'b1, "R4 t2 before end");
    ticks(1);
    fast_state(1'b0, "R4 t2 end");
    tmr_code = 4'd15;
    wr_n(1'b1);
    ticks(62);
    fast_state(1'b1, "R4 t15 before end");
    ticks(1);
    fast_state(1'b0, "R4 t15 end");

    // R6 restart
    tmr_code = 4'd1;
    wr_n(1'b1);
    ticks(5);
    wr_n(1'b1);
    ticks(6);
    fast_state(1'b1, "R6 after restart");
    ticks(1);
    fast_state(1'b0, "R6 end");

    // R7 power-down hold
    wr_n(1'b1);
    ticks(3);
    pwr_down = 1'b1;
    ticks(20);
    fast_state(1'b1, "R7 held");
    pwr_down = 1'b0;
    ticks(3);
    fast_state(1'b1, "R7 resumed");
    ticks(1);
    fast_state(1'b0, "R7 end");

    // R11 gain 0 write stops a running timer
    wr_n(1'b1);
    ticks(2);
    wr_n(1'b0);
    fast_state(1'b0, "R11 stop");

    // R8 init write
    wr_n(1'b1);
    init_wr = 1'b1; cyc(); init_wr = 1'b0; cyc();
    chk({7'd0, cp_hiz}, 8'd1, "R8 parked");
    chk({7'd0, filt_sw_on}, 8'd0, "R8 timer stopped");
    init_wr = 1'b1; gain_in = 1'b0; nreg_wr = 1'b1; cyc();
    init_wr = 1'b0; nreg_wr = 1'b0; cyc();
    chk({7'd0, cp_hiz}, 8'd1, "R8 init wins");
    chk({7'd0, gain_out}, 8'd1, "R8 write dropped");
    wr_n(1'b0);
    chk({7'd0, cp_hiz}, 8'd0, "R8 woken");

    // R9 tri-state request
    wr_n(1'b1);
    tristate_req = 1'b1; cyc();
    chk({7'd0, cp_hiz}, 8'd1, "R9 hiz");
    chk({7'd0, filt_sw_on}, 8'd1, "R9 timer kept");
    tristate_req = 1'b0; cyc();
    chk({7'd0, cp_hiz}, 8'd0, "R9 release");

    // R10 mode leaves armed value mid-run
    fast_mode = 2'b01; cyc();
    chk({7'd0, filt_sw_on}, 8'd0, "R10 sw off");
    chk({7'd0, gain_out}, 8'd1, "R10 gain kept");
    chk({5'd0, cp_code}, {5'd0, cur_fast}, "R10 static fast");
    ticks(10);
    chk({7'd0, gain_out}, 8'd1, "R10 no expiry");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule